// File: doc/BRIEF.md
# Bit-Serial Mesh Processing Cell

This block is a single tile of a rectangular grid of identical processing cells. Each cell exchanges one bit per clock with the cells directly above, below, left and right of it. All cells share one bit clock. Words move through the grid least significant bit first, and each cell transforms them as they pass. The operation and the neighbour routing come from a configuration word. That word is first written into a shadow register and then copied into the active register with a one-cycle load strobe. Software can therefore stage the next setup while the current one keeps running.

The active configuration selects two operand channels (A and B) from the four neighbour inputs. It also selects one of eight operations: pass, serial add, serial subtract, unsigned serial compare, serial-to-parallel capture, parallel-to-serial emission, and two reserved codes that output zero. A programmable word length from 1 to DATA_W bits frames the stream. Each of the four neighbour outputs has its own routing field. That field chooses a neighbour input, the operation result, or a constant zero, so the cell can route bits through while it computes.

Top module: `mesh_cell`

## Requirements
- R1: While rst_ni is low, and after it is released, every output is zero. The active and shadow configurations are all zero, so routing is zero and the operation is pass.
- R2: A cfg_wr_i cycle writes cfg_data_i only into the shadow register and leaves the running behaviour unchanged. A cfg_load_i cycle copies the shadow into the active register, which governs behaviour from the next cycle. The load also restarts the word at bit position 0.
- R3: Each neighbour output is a register updated every cycle from its routing code: 0 zero, 1 north input, 2 south input, 3 east input, 4 west input, 5 operation result, 6 and 7 zero. All four outputs are routed at the same time, and each has a latency of one cycle.
- R4: Configuration layout for DATA_W=8: bits [2:0] word length minus one, [5:3] op, [7:6] source A, [9:8] source B, [12:10] north route, [15:13] south route, [18:16] east route, [21:19] west route. Source codes are 0 north, 1 south, 2 east, 3 west. Neighbour bit indices are 0 north, 1 south, 2 east, 3 west.
- R5: A word spans length-minus-one plus one bits. Position 0 follows automatically after the last bit. word_start_i forces the current bit to be position 0.
- R6: Op 1 (add) outputs the LSB-first sum bit of A+B. The carry is held in one flip-flop and treated as 0 at position 0.
- R7: Op 2 (subtract) outputs the LSB-first bits of A-B, formed as A + not B with a carry of 1 at position 0.
- R8: Op 3 (compare) compares A and B as unsigned values over the word. One cycle after the last bit it raises cmp_valid_o for exactly one cycle, together with exactly one of cmp_gt_o, cmp_eq_o or cmp_lt_o. At all other times all four flags are zero.
- R9: Op 4 (serial-to-parallel) places the bit at position i into bit i of par_o and clears the higher bits. par_o updates one cycle after the last bit, with par_valid_o high for that one cycle, and holds its value otherwise.
- R10: Op 5 (parallel-to-serial) captures par_i at position 0 and emits bit i of the captured value as the result at position i. Changes to par_i later in the word have no effect.
- R11: Ops 0, 3 and 4 forward operand A as the result. Ops 6 and 7 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Array-wide bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write cfg_data_i into the shadow register |
| cfg_data_i | input | CFG_W | Configuration word |
| cfg_load_i | input | 1 | Copy shadow into active configuration |
| word_start_i | input | 1 | Current bit is position 0 |
| nbr_i | input | 4 | Serial bits from neighbours (N,S,E,W = 0..3) |
| nbr_o | output | 4 | Serial bits to neighbours (N,S,E,W = 0..3) |
| par_i | input | DATA_W | Parallel word for serialisation |
| par_o | output | DATA_W | Captured parallel word |
| par_valid_o | output | 1 | par_o updated this cycle |
| cmp_gt_o | output | 1 | A greater than B |
| cmp_eq_o | output | 1 | A equal to B |
| cmp_lt_o | output | 1 | A less than B |
| cmp_valid_o | output | 1 | Compare result valid |

## Verification
A bad carry or a bad bit position shows up on the routed result output in the same word. A carry that is not cleared at a word boundary corrupts bit 0 of the next word, one cycle after that bit enters. A wrong compare or capture state appears only as the flags or par_o one cycle after the last bit, so each word is checked at that boundary. A configuration copied early or late changes the neighbour outputs one cycle after the stray strobe, so routing patterns are checked on the cycle that follows each load.

// File: rtl/cell_pkg.sv
package cell_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_CMP  = 3'd3,
    OP_S2P  = 3'd4,
    OP_P2S  = 3'd5,
    OP_NUL6 = 3'd6,
    OP_NUL7 = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    RT_ZERO = 3'd0,
    RT_N    = 3'd1,
    RT_S    = 3'd2,
    RT_E    = 3'd3,
    RT_W    = 3'd4,
    RT_RES  = 3'd5,
    RT_RSV6 = 3'd6,
    RT_RSV7 = 3'd7
  } route_e;

  localparam int NUM_DIR = 4;
  localparam int DIR_N = 0;
  localparam int DIR_S = 1;
  localparam int DIR_E = 2;
  localparam int DIR_W = 3;

  typedef logic [1:0] src_t;

  typedef struct packed {
    route_e rt_w;
    route_e rt_e;
    route_e rt_s;
    route_e rt_n;
    src_t   src_b;
    src_t   src_a;
    op_e    op;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_GT = 2'd1,
    REL_LT = 2'd2
  } rel_e;

endpackage

// File: rtl/cell_cfg_regs.sv
module cell_cfg_regs #(
  parameter int CFG_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  input  logic             load_i,
  output logic [CFG_W-1:0] active_o
);
  logic [CFG_W-1:0] shadow_q;
  logic [CFG_W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_i)   shadow_q <= data_i;
      // load copies the pre-edge shadow; a same-cycle write lands next time
      if (load_i) active_q <= shadow_q;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/cell_seq.sv
module cell_seq #(
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             word_start_i,
  input  logic [LEN_W-1:0] len_m1_i,
  output logic [LEN_W-1:0] pos_o,
  output logic             first_o,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] pos;

  assign pos     = word_start_i ? '0 : cnt_q;
  assign first_o = (pos == '0);
  assign last_o  = (pos == len_m1_i);
  assign pos_o   = pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else              cnt_q <= pos + 1'b1;
  end
endmodule

// File: rtl/cell_alu.sv
module cell_alu
  import cell_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [LEN_W-1:0]  pos_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic              a_i,
  input  logic              b_i,
  input  logic [DATA_W-1:0] par_i,
  output logic              res_o,
  output logic              gt_o,
  output logic              eq_o,
  output logic              lt_o,
  output logic              cmp_valid_o,
  output logic [DATA_W-1:0] par_o,
  output logic              par_valid_o
);
  logic              carry_q, carry_in, b_eff, sum_bit, carry_out;
  rel_e              rel_q, rel_d;
  logic [DATA_W-1:0] acc_q, acc_d, hold_q;
  logic              ser_bit;
  logic              gt_q, eq_q, lt_q, cvalid_q, pvalid_q;
  logic [DATA_W-1:0] par_q;

  // serial adder / subtractor
  assign b_eff     = (op_i == OP_SUB) ? ~b_i : b_i;
  assign carry_in  = first_i ? (op_i == OP_SUB) : carry_q;
  assign sum_bit   = a_i ^ b_eff ^ carry_in;
  assign carry_out = (a_i & b_eff) | (a_i & carry_in) | (b_eff & carry_in);

  // LSB-first compare: a later differing bit overrides
  always_comb begin
    if (a_i != b_i)   rel_d = a_i ? REL_GT : REL_LT;
    else if (first_i) rel_d = REL_EQ;
    else              rel_d = rel_q;
  end

  // serial to parallel accumulation
  always_comb begin
    acc_d = first_i ? '0 : acc_q;
    acc_d[pos_i] = a_i;
  end

  // parallel to serial
  assign ser_bit = first_i ? par_i[0] : hold_q[pos_i];

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB:         res_o = sum_bit;
      OP_P2S:                 res_o = ser_bit;
      OP_PASS, OP_CMP, OP_S2P: res_o = a_i;
      default:                res_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q  <= 1'b0;
      rel_q    <= REL_EQ;
      acc_q    <= '0;
      hold_q   <= '0;
      gt_q     <= 1'b0;
      eq_q     <= 1'b0;
      lt_q     <= 1'b0;
      cvalid_q <= 1'b0;
      par_q    <= '0;
      pvalid_q <= 1'b0;
    end else begin
      carry_q <= carry_out;
      rel_q   <= rel_d;
      acc_q   <= acc_d;
      if (first_i) hold_q <= par_i;
      if (last_i && op_i == OP_CMP) begin
        gt_q     <= (rel_d == REL_GT);
        eq_q     <= (rel_d == REL_EQ);
        lt_q     <= (rel_d == REL_LT);
        cvalid_q <= 1'b1;
      end else begin
        gt_q     <= 1'b0;
        eq_q     <= 1'b0;
        lt_q     <= 1'b0;
        cvalid_q <= 1'b0;
      end
      pvalid_q <= last_i && (op_i == OP_S2P);
      if (last_i && op_i == OP_S2P) par_q <= acc_d;
    end
  end

  assign gt_o        = gt_q;
  assign eq_o        = eq_q;
  assign lt_o        = lt_q;
  assign cmp_valid_o = cvalid_q;
  assign par_o       = par_q;
  assign par_valid_o = pvalid_q;
endmodule

// File: rtl/cell_router.sv
module cell_router
  import cell_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ctl_t               ctl_i,
  input  logic [NUM_DIR-1:0] nbr_i,
  input  logic               res_i,
  output logic [NUM_DIR-1:0] nbr_o
);
  route_e sel [NUM_DIR];

  assign sel[DIR_N] = ctl_i.rt_n;
  assign sel[DIR_S] = ctl_i.rt_s;
  assign sel[DIR_E] = ctl_i.rt_e;
  assign sel[DIR_W] = ctl_i.rt_w;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_out
    logic nxt, q;
    always_comb begin
      unique case (sel[d])
        RT_N:    nxt = nbr_i[DIR_N];
        RT_S:    nxt = nbr_i[DIR_S];
        RT_E:    nxt = nbr_i[DIR_E];
        RT_W:    nxt = nbr_i[DIR_W];
        RT_RES:  nxt = res_i;
        default: nxt = 1'b0;
      endcase
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= nxt;
    end
    assign nbr_o[d] = q;
  end
endmodule

// File: rtl/mesh_cell.sv
module mesh_cell
  import cell_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W),
  localparam int CFG_W = CTL_W + LEN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [CFG_W-1:0]   cfg_data_i,
  input  logic               cfg_load_i,
  input  logic               word_start_i,
  input  logic [NUM_DIR-1:0] nbr_i,
  output logic [NUM_DIR-1:0] nbr_o,
  input  logic [DATA_W-1:0]  par_i,
  output logic [DATA_W-1:0]  par_o,
  output logic               par_valid_o,
  output logic               cmp_gt_o,
  output logic               cmp_eq_o,
  output logic               cmp_lt_o,
  output logic               cmp_valid_o
);
  logic [CFG_W-1:0] act_word;
  ctl_t             act_ctl;
  logic [LEN_W-1:0] len_m1;
  logic [LEN_W-1:0] pos;
  logic             first, last, opa, opb, res;

  cell_cfg_regs #(.CFG_W(CFG_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .data_i  (cfg_data_i),
    .load_i  (cfg_load_i),
    .active_o(act_word)
  );

  assign len_m1  = act_word[LEN_W-1:0];
  assign act_ctl = ctl_t'(act_word[CFG_W-1:LEN_W]);
  assign opa     = nbr_i[act_ctl.src_a];
  assign opb     = nbr_i[act_ctl.src_b];

  cell_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cfg_load_i),
    .word_start_i(word_start_i),
    .len_m1_i    (len_m1),
    .pos_o       (pos),
    .first_o     (first),
    .last_o      (last)
  );

  cell_alu #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_alu (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (act_ctl.op),
    .pos_i      (pos),
    .first_i    (first),
    .last_i     (last),
    .a_i        (opa),
    .b_i        (opb),
    .par_i      (par_i),
    .res_o      (res),
    .gt_o       (cmp_gt_o),
    .eq_o       (cmp_eq_o),
    .lt_o       (cmp_lt_o),
    .cmp_valid_o(cmp_valid_o),
    .par_o      (par_o),
    .par_valid_o(par_valid_o)
  );

  cell_router u_rt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctl_i (act_ctl),
    .nbr_i (nbr_i),
    .res_i (res),
    .nbr_o (nbr_o)
  );
endmodule

// File: rtl/mesh_cell_chk.sv
module mesh_cell_chk
  import cell_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 22
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_load_i,
  input logic [NUM_DIR-1:0] nbr_i,
  input logic [NUM_DIR-1:0] nbr_o,
  input logic [DATA_W-1:0]  par_o,
  input logic               par_valid_o,
  input logic               cmp_gt_o,
  input logic               cmp_eq_o,
  input logic               cmp_lt_o,
  input logic               cmp_valid_o,
  input logic [CFG_W-1:0]   act_word,
  input ctl_t               act_ctl
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_cmp_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_o |-> $onehot({cmp_gt_o, cmp_eq_o, cmp_lt_o}));

  p_cmp_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_o |-> ({cmp_gt_o, cmp_eq_o, cmp_lt_o} == 3'b000));

  p_par_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !par_valid_o) |-> $stable(par_o));

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(cfg_load_i)) |-> $stable(act_word));

  p_route_north_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(act_ctl.rt_s) == RT_N) |-> (nbr_o[DIR_S] == $past(nbr_i[DIR_N])));

  p_route_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(act_ctl.rt_e) == RT_ZERO) |-> !nbr_o[DIR_E]);
endmodule

bind mesh_cell mesh_cell_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .nbr_i      (nbr_i),
  .nbr_o      (nbr_o),
  .par_o      (par_o),
  .par_valid_o(par_valid_o),
  .cmp_gt_o   (cmp_gt_o),
  .cmp_eq_o   (cmp_eq_o),
  .cmp_lt_o   (cmp_lt_o),
  .cmp_valid_o(cmp_valid_o),
  .act_word   (act_word),
  .act_ctl    (act_ctl)
);

// File: tb/mesh_cell_bench.sv
`timescale 1ns/100ps
module mesh_cell_bench;
  localparam int DW = 8;
  localparam int CW = 22;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_wr_i = 1'b0;
  logic [CW-1:0] cfg_data_i = '0;
  logic          cfg_load_i = 1'b0;
  logic          word_start_i = 1'b0;
  logic [3:0]    nbr_i = '0;
  logic [3:0]    nbr_o;
  logic [DW-1:0] par_i = '0;
  logic [DW-1:0] par_o;
  logic          par_valid_o, cmp_gt_o, cmp_eq_o, cmp_lt_o, cmp_valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mesh_cell u_mesh_cell (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i),
    .cfg_load_i(cfg_load_i), .word_start_i(word_start_i), .nbr_i(nbr_i),
    .nbr_o(nbr_o), .par_i(par_i), .par_o(par_o), .par_valid_o(par_valid_o),
    .cmp_gt_o(cmp_gt_o), .cmp_eq_o(cmp_eq_o), .cmp_lt_o(cmp_lt_o),
    .cmp_valid_o(cmp_valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // R4 layout
  function automatic logic [CW-1:0] mk(input logic [2:0] op, input logic [2:0] len_m1,
      input logic [1:0] sa, input logic [1:0] sb,
      input logic [2:0] rn, input logic [2:0] rs, input logic [2:0] re, input logic [2:0] rw);
    return {rw, re, rs, rn, sb, sa, op, len_m1};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_cfg(input logic [CW-1:0] c);
    cfg_wr_i = 1'b1; cfg_data_i = c; tick();
    cfg_wr_i = 1'b0; cfg_load_i = 1'b1; tick();
    cfg_load_i = 1'b0;
  endtask

  // A on north, B on south, result routed east
  task automatic run_word(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                          input bit ws, input string req);
    logic [7:0] ev;
    case (op)
      3'd1: ev = a + b;
      3'd2: ev = a - b;
      3'd0, 3'd3, 3'd4: ev = a;
      default: ev = 8'h00;
    endcase
    for (int i = 0; i < 8; i++) begin
      nbr_i = {2'b00, b[i], a[i]};
      word_start_i = ws && (i == 0);
      tick();
      if (op == 3'd3) begin
        if (i < 7) chk(cmp_valid_o == 1'b0, req, cmp_valid_o, 0);
        else chk({cmp_valid_o, cmp_gt_o, cmp_eq_o, cmp_lt_o} ==
                 {1'b1, a > b, a == b, a < b}, req,
                 {cmp_valid_o, cmp_gt_o, cmp_eq_o, cmp_lt_o},
                 {1'b1, a > b, a == b, a < b});
      end
      chk(nbr_o[2] == ev[i], req, nbr_o[2], ev[i]);
    end
    word_start_i = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] b;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd1, 8'h00, 8'h00},
    '{3'd1, 8'h5A, 8'h33},
    '{3'd1, 8'hFF, 8'h01},
    '{3'd2, 8'h40, 8'h01},
    '{3'd2, 8'h01, 8'h02},
    '{3'd3, 8'h80, 8'h7F},
    '{3'd3, 8'h3C, 8'h3C},
    '{3'd3, 8'h01, 8'h80},
    '{3'd3, 8'hFE, 8'hFF},
    '{3'd0, 8'hC3, 8'h00}
  };

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1 reset
    #12;
    chk({nbr_o, par_o, par_valid_o, cmp_gt_o, cmp_eq_o, cmp_lt_o, cmp_valid_o} == '0,
        "R1 in reset", {nbr_o, par_o}, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    nbr_i = 4'hF;
    tick(); tick();
    chk(nbr_o == 4'h0, "R1 zero routing after reset", nbr_o, 0);
    chk(par_o == '0 && !cmp_valid_o, "R1 zero flags after reset", par_o, 0);

    // table walk: R6 R7 R8 R11
    for (int v = 0; v < 10; v++) begin
      load_cfg(mk(VECS[v].op, 3'd7, 2'd0, 2'd1, 3'd0, 3'd0, 3'd5, 3'd0));
      run_word(VECS[v].a, VECS[v].b, VECS[v].op, 1'b1,
               VECS[v].op == 3'd1 ? "R6 add" : VECS[v].op == 3'd2 ? "R7 sub" :
               VECS[v].op == 3'd3 ? "R8 cmp" : "R11 pass");
    end

    // R5 R6: auto-wrapped second word starts with cleared carry
    load_cfg(mk(3'd1, 3'd7, 2'd0, 2'd1, 3'd0, 3'd0, 3'd5, 3'd0));
    run_word(8'hFF, 8'h01, 3'd1, 1'b1, "R6 carry out word");
    run_word(8'h00, 8'h00, 3'd1, 1'b0, "R5 auto wrap clears carry");

    // R5: word_start mid word resyncs, carry dropped
    nbr_i = 4'b0011; word_start_i = 1'b1; tick();
    chk(nbr_o[2] == 1'b0, "R6 1+1 bit0", nbr_o[2], 0);
    nbr_i = 4'b0000; word_start_i = 1'b1; tick();
    chk(nbr_o[2] == 1'b0, "R5 word_start clears carry", nbr_o[2], 0);
    word_start_i = 1'b0;

    // R2: shadow write during a running word has no effect
    cfg_wr_i = 1'b1;
    cfg_data_i = mk(3'd0, 3'd7, 2'd0, 2'd0, 3'd4, 3'd1, 3'd2, 3'd3);
    run_word(8'h0F, 8'h0F, 3'd1, 1'b1, "R2 shadow ignored");
    cfg_wr_i = 1'b0;
    run_word(8'h21, 8'h12, 3'd1, 1'b1, "R2 still active add");
    cfg_load_i = 1'b1; nbr_i = 4'b0000; tick();
    cfg_load_i = 1'b0;

    // R3 R4 routing: N<-W, S<-N, E<-S, W<-E
    nbr_i = 4'b0001; tick();
    chk(nbr_o == 4'b0010, "R3 north to south out", nbr_o, 4'b0010);
    nbr_i = 4'b1000; tick();
    chk(nbr_o == 4'b0001, "R3 west to north out", nbr_o, 4'b0001);
    nbr_i = 4'b0100; tick();
    chk(nbr_o == 4'b1000, "R3 east to west out", nbr_o, 4'b1000);
    nbr_i = 4'b0010; tick();
    chk(nbr_o == 4'b0100, "R4 south to east out", nbr_o, 4'b0100);
    nbr_i = 4'b1111; tick();
    chk(nbr_o == 4'b1111, "R3 concurrent", nbr_o, 4'b1111);
    load_cfg(mk(3'd0, 3'd7, 2'd0, 2'd0, 3'd6, 3'd7, 3'd0, 3'd0));
    nbr_i = 4'b1111; tick();
    chk(nbr_o == 4'b0000, "R3 reserved route codes", nbr_o, 0);

    // R9 serial to parallel, length 4
    load_cfg(mk(3'd4, 3'd3, 2'd0, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0));
    for (int i = 0; i < 4; i++) begin
      nbr_i = {3'b000, (i != 1)};
      word_start_i = (i == 0);
      tick();
      if (i < 3) chk(par_valid_o == 1'b0, "R9 no early valid", par_valid_o, 0);
    end
    word_start_i = 1'b0;
    chk(par_valid_o && par_o == 8'h0D, "R9 capture", {par_valid_o, par_o}, {1'b1, 8'h0D});
    nbr_i = 4'b0001; tick();
    chk(!par_valid_o && par_o == 8'h0D, "R9 hold", {par_valid_o, par_o}, {1'b0, 8'h0D});

    // R10 parallel to serial, later par_i ignored
    load_cfg(mk(3'd5, 3'd7, 2'd0, 2'd0, 3'd0, 3'd0, 3'd5, 3'd0));
    for (int i = 0; i < 8; i++) begin
      par_i = (i == 0) ? 8'hA5 : 8'h3C;
      word_start_i = (i == 0);
      nbr_i = 4'b0000;
      tick();
      chk(nbr_o[2] == ((8'hA5 >> i) & 1), "R10 serial bit", nbr_o[2], (8'hA5 >> i) & 1);
    end
    word_start_i = 1'b0;

    // R11 null ops
    load_cfg(mk(3'd6, 3'd7, 2'd0, 2'd1, 3'd0, 3'd0, 3'd5, 3'd0));
    run_word(8'hFF, 8'hFF, 3'd6, 1'b1, "R11 op6 zero");
    load_cfg(mk(3'd7, 3'd7, 2'd0, 2'd1, 3'd0, 3'd0, 3'd5, 3'd0));
    run_word(8'hAA, 8'h55, 3'd7, 1'b1, "R11 op7 zero");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule